// File: doc/BRIEF.md
# Timestamped Statistics Counter Bank

This block keeps a bank of wrapping event counters for a packet-processing port: packets arriving from and leaving for the line side, packets to and from each of eight switch ports, packets exchanged with an attached processor in both directions, and five kinds of drop event. Each counter advances by one on every clock cycle in which its event strobe is high. All strobes can be active in the same cycle, and every one of them is counted.

Software reads a counter by presenting its index on a valid/ready request channel. In the cycle the request is accepted, the block captures the selected counter together with a free-running cycle timestamp. The pair is held in a single response register until the consumer accepts it. Because both values are taken at the same clock edge, two reads of one counter give an exact count over an exact number of cycles, and software can compute a rate from them. Reads never clear a counter. An index with no counter behind it returns zero and raises an error flag.

Back-pressure works as follows. A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is high whenever the response register is empty or is being emptied in the same cycle. A response stays valid, with all its fields unchanged, until `rsp_ready` is seen high at a rising edge.

Top module: `stat_bank`

## Requirements
- R1: While `rst` is high and after it falls, all counters and the timestamp are zero, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The index map is fixed. Index 0 is line receive and 16 is line transmit. Indices 4..11 are switch ports 0..7 inbound (`ev_port_rx[k]`). 20..27 are switch ports 0..7 outbound (`ev_port_tx[k]`). 12 and 13 are processor-to-datapath on the ingress and egress side (`ev_proc_rx[0]`, `[1]`). 28 and 29 are datapath-to-processor on the ingress and egress side (`ev_proc_tx[0]`, `[1]`). 64..68 are `ev_drop[0..4]`: reassembly cell drop, invalid packet, line queue drop, switch queue drop, processor queue drop.
- R3: A request accepted at edge t produces, from edge t onward, `rsp_valid`=1 with `rsp_count` equal to the counter value held just before edge t and `rsp_stamp` equal to the timestamp held just before edge t. The timestamp is zero during reset and increments by one at every edge after reset.
- R4: An event strobe sampled at the same edge that accepts a read of its counter is not included in that response. It is included in the next read.
- R5: All 27 strobes high in one cycle advance all 27 counters by exactly one each.
- R6: A read of any index outside the map returns `rsp_count`=0 and `rsp_err`=1. A mapped index returns `rsp_err`=0.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0, a pending request is not taken, and `rsp_count`, `rsp_stamp` and `rsp_err` stay unchanged even if events occur.
- R8: Counters wrap modulo 2^CNT_W.
- R9: Reading a counter does not change it.
- R10: With `rsp_ready` held at 1, a new request can be accepted at every edge, and each response appears one cycle after the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_link_rx | input | 1 | Packet received from line |
| ev_port_rx | input | 8 | Packet received from switch port k |
| ev_proc_rx | input | 2 | Packet from processor, bit0 ingress side, bit1 egress side |
| ev_link_tx | input | 1 | Packet sent to line |
| ev_port_tx | input | 8 | Packet sent to switch port k |
| ev_proc_tx | input | 2 | Packet to processor, bit0 ingress side, bit1 egress side |
| ev_drop | input | 5 | Drop events, bit order as in R2 |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a request |
| req_index | input | 7 | Counter index to read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_count | output | CNT_W | Captured counter value |
| rsp_stamp | output | TS_W | Timestamp captured with it |
| rsp_err | output | 1 | Index was unmapped |

## Verification
The hardest case to create from the ports is a read whose acceptance edge falls in the same cycle as an increment of that counter, because the increment must be left out of that response and show up in the next one. The bench raises the strobe and the request on the same falling edge. It then reads the counter again to find the deferred increment. A second hard case is a stalled response with events arriving and a new request waiting. To reach it, the bench holds `rsp_ready` low for several cycles while it pulses the read counter and offers another request.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int IDX_W          = 7;
  localparam int NUM_PORTS      = 8;
  localparam int NUM_PROC       = 2;
  localparam int NUM_DROPS      = 5;
  localparam int IDX_LINK_RX    = 0;
  localparam int IDX_PORT_RX    = 4;
  localparam int IDX_LINK_TX    = 16;
  localparam int IDX_PORT_TX    = 20;
  localparam int IDX_DROP       = 64;
  // one direction: line + ports + processor pair
  localparam int SLOTS_PER_DIR  = 1 + NUM_PORTS + NUM_PROC;
  localparam int NUM_SLOTS      = 2 * SLOTS_PER_DIR + NUM_DROPS;
  localparam int SLOT_W         = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_sel_t;

  function automatic slot_sel_t map_index(input logic [IDX_W-1:0] idx);
    slot_sel_t r;
    int ix;
    int s;
    ix = int'(idx);
    s  = 0;
    r.hit = 1'b1;
    if (ix == IDX_LINK_RX)
      s = 0;
    else if (ix >= IDX_PORT_RX && ix < IDX_PORT_RX + NUM_PORTS + NUM_PROC)
      s = ix - IDX_PORT_RX + 1;
    else if (ix == IDX_LINK_TX)
      s = SLOTS_PER_DIR;
    else if (ix >= IDX_PORT_TX && ix < IDX_PORT_TX + NUM_PORTS + NUM_PROC)
      s = ix - IDX_PORT_TX + SLOTS_PER_DIR + 1;
    else if (ix >= IDX_DROP && ix < IDX_DROP + NUM_DROPS)
      s = ix - IDX_DROP + 2 * SLOTS_PER_DIR;
    else
      r.hit = 1'b0;
    r.slot = SLOT_W'(s);
    return r;
  endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

  // R8: any change is a single modular step
  p_single_step_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/stat_timebase.sv
module stat_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else now <= now + W'(1);
  end
endmodule

// File: rtl/stat_index_decode.sv
module stat_index_decode
  import stat_bank_pkg::*;
(
  input  logic [IDX_W-1:0]  index,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);
  slot_sel_t sel;
  always_comb begin
    sel  = map_index(index);
    hit  = sel.hit;
    slot = sel.slot;
  end
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port #(
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             sel_hit,
  input  logic [CNT_W-1:0] sel_count,
  input  logic [TS_W-1:0]  stamp_now,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_count,
  output logic [TS_W-1:0]  rsp_stamp,
  output logic             rsp_err
);
  logic take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_count <= '0;
      rsp_stamp <= '0;
      rsp_err   <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_count <= sel_hit ? sel_count : '0;
      rsp_stamp <= stamp_now;
      rsp_err   <= !sel_hit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7: a stalled response holds every field
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_count) &&
                                   $stable(rsp_stamp) && $stable(rsp_err)));
  // R7: no request taken while the response is stalled
  p_no_take_stalled_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R6: an error response never carries a count
  p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_count == '0));
  // R3: stamp and count come from the acceptance cycle
  p_stamp_coherent_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> (rsp_valid && rsp_stamp == $past(stamp_now) &&
              rsp_count == ($past(sel_hit) ? $past(sel_count) : '0)));
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_link_rx,
  input  logic [NUM_PORTS-1:0] ev_port_rx,
  input  logic [NUM_PROC-1:0]  ev_proc_rx,
  input  logic                 ev_link_tx,
  input  logic [NUM_PORTS-1:0] ev_port_tx,
  input  logic [NUM_PROC-1:0]  ev_proc_tx,
  input  logic [NUM_DROPS-1:0] ev_drop,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [IDX_W-1:0]     req_index,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [CNT_W-1:0]     rsp_count,
  output logic [TS_W-1:0]      rsp_stamp,
  output logic                 rsp_err
);
  // slot order follows the index map: inbound, outbound, drops
  logic [NUM_SLOTS-1:0] evt_vec;
  logic [CNT_W-1:0]     cnt_arr [NUM_SLOTS];
  logic [CNT_W-1:0]     sel_count;
  logic [TS_W-1:0]      stamp_now;
  logic                 sel_hit;
  logic [SLOT_W-1:0]    sel_slot;

  assign evt_vec = {ev_drop, ev_proc_tx, ev_port_tx, ev_link_tx,
                    ev_proc_rx, ev_port_rx, ev_link_rx};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cnt
    stat_counter #(.W(CNT_W)) i_cnt (
      .clk (clk),
      .rst (rst),
      .inc (evt_vec[g]),
      .cnt (cnt_arr[g])
    );
  end

  stat_timebase #(.W(TS_W)) i_time (
    .clk (clk),
    .rst (rst),
    .now (stamp_now)
  );

  stat_index_decode i_dec (
    .index (req_index),
    .hit   (sel_hit),
    .slot  (sel_slot)
  );

  assign sel_count = (int'(sel_slot) < NUM_SLOTS) ? cnt_arr[sel_slot] : '0;

  stat_read_port #(.CNT_W(CNT_W), .TS_W(TS_W)) i_rd (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sel_hit   (sel_hit),
    .sel_count (sel_count),
    .stamp_now (stamp_now),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_count (rsp_count),
    .rsp_stamp (rsp_stamp),
    .rsp_err   (rsp_err)
  );

  // R5: every strobed counter moves in the same edge
  p_all_strobes_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_vec[0] && evt_vec[NUM_SLOTS-1]) |=>
      (cnt_arr[0] == $past(cnt_arr[0]) + CNT_W'(1) &&
       cnt_arr[NUM_SLOTS-1] == $past(cnt_arr[NUM_SLOTS-1]) + CNT_W'(1)));
endmodule

// File: tb/test_stat_bank.sv
module test_stat_bank;
  localparam int CW = 8;
  localparam int TW = 16;
  localparam int NS = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] evt = '0;
  logic req_valid = 1'b0;
  logic [6:0] req_index = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_err;
  logic [CW-1:0] rsp_count;
  logic [TW-1:0] rsp_stamp;
  logic [TW-1:0] tb_ts;
  logic [CW-1:0] mdl [NS];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tb_ts <= '0;
    else tb_ts <= tb_ts + TW'(1);
  end

  stat_bank #(.CNT_W(CW), .TS_W(TW)) i_stat_bank (
    .clk(clk), .rst(rst),
    .ev_link_rx(evt[0]), .ev_port_rx(evt[8:1]), .ev_proc_rx(evt[10:9]),
    .ev_link_tx(evt[11]), .ev_port_tx(evt[19:12]), .ev_proc_tx(evt[21:20]),
    .ev_drop(evt[26:22]),
    .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_count(rsp_count),
    .rsp_stamp(rsp_stamp), .rsp_err(rsp_err)
  );

  // entries: index, slot to pulse, pulses, expected error (R2, R6)
  localparam logic [31:0] VEC [20] = '{
    {8'd0,  8'd0,  8'd3, 8'd0}, {8'd4,  8'd1,  8'd1, 8'd0},
    {8'd11, 8'd8,  8'd2, 8'd0}, {8'd12, 8'd9,  8'd4, 8'd0},
    {8'd13, 8'd10, 8'd1, 8'd0}, {8'd16, 8'd11, 8'd5, 8'd0},
    {8'd20, 8'd12, 8'd2, 8'd0}, {8'd27, 8'd19, 8'd3, 8'd0},
    {8'd28, 8'd20, 8'd1, 8'd0}, {8'd29, 8'd21, 8'd2, 8'd0},
    {8'd64, 8'd22, 8'd3, 8'd0}, {8'd65, 8'd23, 8'd1, 8'd0},
    {8'd66, 8'd24, 8'd2, 8'd0}, {8'd67, 8'd25, 8'd1, 8'd0},
    {8'd68, 8'd26, 8'd4, 8'd0}, {8'd1,  8'd2,  8'd2, 8'd1},
    {8'd14, 8'd3,  8'd1, 8'd1}, {8'd17, 8'd4,  8'd1, 8'd1},
    {8'd69, 8'd5,  8'd1, 8'd1}, {8'd127,8'd6,  8'd1, 8'd1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    @(negedge clk);
    evt = m;
    for (int b = 0; b < NS; b++) if (m[b]) mdl[b] = mdl[b] + CW'(1);
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd(input logic [6:0] idx, input logic [CW-1:0] ec, input logic ee, input string tag);
    logic [TW-1:0] st;
    @(negedge clk);
    req_valid = 1'b1;
    req_index = idx;
    st = tb_ts;
    @(negedge clk);
    req_valid = 1'b0;
    chk(32'(rsp_valid), 32'd1, {tag, " valid"});
    chk(32'(rsp_count), 32'(ec), {tag, " count"});
    chk(32'(rsp_err), 32'(ee), {tag, " err"});
    chk(32'(rsp_stamp), 32'(st), {tag, " stamp R3"});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < NS; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] s1, s2;
    logic [CW-1:0] e1, e2;
    do_reset();
    // R1: idle state after reset
    @(negedge clk);
    chk(32'(rsp_valid), 32'd0, "R1 rsp_valid after reset");
    chk(32'(req_ready), 32'd1, "R1 req_ready after reset");
    rd(7'd0, '0, 1'b0, "R1 counter zero");

    // R2 / R6: table walk
    for (int v = 0; v < 20; v++) begin
      for (int n = 0; n < int'(VEC[v][15:8]); n++) pulse(NS'(1) << VEC[v][23:16]);
      rd(VEC[v][30:24], VEC[v][0] ? CW'(0) : mdl[VEC[v][23:16]], VEC[v][0], "R2 R6 table");
    end

    // R9: repeated reads leave the counter unchanged
    rd(7'd64, mdl[22], 1'b0, "R9 first read");
    rd(7'd64, mdl[22], 1'b0, "R9 second read");

    // R4: increment in the accepting cycle falls after the snapshot
    @(negedge clk);
    req_valid = 1'b1;
    req_index = 7'd16;
    evt[11] = 1'b1;
    e1 = mdl[11];
    s1 = tb_ts;
    mdl[11] = mdl[11] + CW'(1);
    @(negedge clk);
    req_valid = 1'b0;
    evt = '0;
    chk(32'(rsp_count), 32'(e1), "R4 coincident read excludes event");
    chk(32'(rsp_stamp), 32'(s1), "R4 coincident stamp");
    rd(7'd16, mdl[11], 1'b0, "R4 next read includes event");

    // R5: all strobes together
    repeat (3) pulse('1);
    rd(7'd0, mdl[0], 1'b0, "R5 slot line rx");
    rd(7'd13, mdl[10], 1'b0, "R5 slot proc rx egress");
    rd(7'd29, mdl[21], 1'b0, "R5 slot proc tx egress");
    rd(7'd68, mdl[26], 1'b0, "R5 slot proc queue drop");

    // R7: stalled response with events and a waiting request
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_index = 7'd20;
    e1 = mdl[12];
    s1 = tb_ts;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      evt = NS'(1) << 12;
      req_valid = 1'b1;
      req_index = 7'd0;
      mdl[12] = mdl[12] + CW'(1);
      @(negedge clk);
      chk(32'(rsp_valid), 32'd1, "R7 held valid");
      chk(32'(rsp_count), 32'(e1), "R7 held count");
      chk(32'(rsp_stamp), 32'(s1), "R7 held stamp");
      chk(32'(req_ready), 32'd0, "R7 req_ready low");
    end
    evt = '0;
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(32'(rsp_valid), 32'd0, "R7 pending request not taken");
    chk(32'(req_ready), 32'd1, "R7 ready after drain");
    rd(7'd20, mdl[12], 1'b0, "R7 stalled events counted");

    // R10: back-to-back reads
    @(negedge clk);
    req_valid = 1'b1;
    req_index = 7'd4;
    e1 = mdl[1];
    s1 = tb_ts;
    @(negedge clk);
    req_index = 7'd28;
    e2 = mdl[20];
    s2 = tb_ts;
    chk(32'(rsp_count), 32'(e1), "R10 first count");
    chk(32'(rsp_stamp), 32'(s1), "R10 first stamp");
    chk(32'(req_ready), 32'd1, "R10 ready during stream");
    @(negedge clk);
    req_valid = 1'b0;
    chk(32'(rsp_valid), 32'd1, "R10 second valid");
    chk(32'(rsp_count), 32'(e2), "R10 second count");
    chk(32'(rsp_stamp), 32'(s2), "R10 second stamp");

    // R8: wrap of the line receive counter
    for (int i = 0; i < 300; i++) pulse(NS'(1));
    rd(7'd0, mdl[0], 1'b0, "R8 wrapped count");

    // R1: mid-run reset clears counters and stamp
    do_reset();
    rd(7'd16, '0, 1'b0, "R1 cleared after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule